// File: doc/BRIEF.md
# Two-Channel Double-Buffered Converter Input Stage

This block is the digital front end of a two-channel 14-bit converter. Each channel holds its data in two register stages. A write pulse places the bus word into a staging register. A separate update pulse then moves the staged word into the output register, which drives the converter. Each channel's output register feeds a primary code and its complement. Together these two codes stand in for the pair of complementary output currents.

A mode input selects one of two operating modes. In dual-port mode each channel has its own data bus, write pulse and update pulse, and the two channels run independently. In interleaved mode only the channel-0 bus and pulses are used. Successive writes go to channel 0 and channel 1 in turn. Both output registers load together on every second update pulse. Strobes are one-cycle-wide enables sampled on a single system clock. Each enable marks a rising edge of the corresponding converter-side strobe.

Top module: `dual_dac_front`

## Requirements
- R1: Data words are 14-bit straight binary, with bit 13 as the MSB and bit 0 as the LSB; an output code of 16383 (all ones) is full-scale.
- R2: Each channel's complementary output always equals 16383 minus its primary output.
- R3: A write pulse captures the data bus into the staging register only; the output code does not change on a write alone.
- R4: With `dual_mode`=1, an update pulse on a channel copies that channel's staging register into its output register, and the output changes on no other cycle.
- R5: When a write and an update pulse arrive in the same cycle, the output takes the previously staged word and the new word becomes visible after the next update (one-stage latency).
- R6: With `dual_mode`=1, strobes and data of one channel have no effect on the other channel.
- R7: With `dual_mode`=0, each write pulse on the channel-0 port loads channel 0 and channel 1 alternately, starting with channel 0 after reset.
- R8: With `dual_mode`=0, update pulses on the channel-0 port are counted alternately; both output registers load together on the second, fourth, and so on, after reset, and hold on the others.
- R9: With `dual_mode`=0, the channel-1 data bus and strobes are ignored.
- R10: A synchronous active-high reset clears all staging and output registers to zero and returns both interleave toggles to their first state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 = independent channels, 0 = interleaved on the channel-0 port |
| a_data | input | 14 | Channel-0 data bus (shared bus in interleaved mode) |
| a_wr | input | 1 | Channel-0 write pulse |
| a_upd | input | 1 | Channel-0 update pulse |
| b_data | input | 14 | Channel-1 data bus |
| b_wr | input | 1 | Channel-1 write pulse |
| b_upd | input | 1 | Channel-1 update pulse |
| a_code | output | 14 | Channel-0 output code |
| a_code_n | output | 14 | Channel-0 complementary code |
| b_code | output | 14 | Channel-1 output code |
| b_code_n | output | 14 | Channel-1 complementary code |

## Verification
The assertions assume that every input is stable around the clock edge and that a strobe held high counts as one event per clock. They also assume that a mode change, when one occurs, leaves the interleave toggles where they were. The bench drives all inputs on the falling edge, so they are settled by the sampling edge. It changes `dual_mode` only while reset is held, so each mode starts from cleared toggles. The random phases include simultaneous write and update pulses and back-to-back strobes. In interleaved mode they also place noise on the channel-1 bus and strobes.

// File: rtl/dual_dac_front.sv
module dual_dac_front #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dual_mode,
  input  logic [DW-1:0] a_data,
  input  logic          a_wr,
  input  logic          a_upd,
  input  logic [DW-1:0] b_data,
  input  logic          b_wr,
  input  logic          b_upd,
  output logic [DW-1:0] a_code,
  output logic [DW-1:0] a_code_n,
  output logic [DW-1:0] b_code,
  output logic [DW-1:0] b_code_n
);
  logic [DW-1:0] a_stage, b_stage;
  logic          wr_sel;
  logic          upd_ph;

  assign a_code_n = ~a_code;
  assign b_code_n = ~b_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_stage <= '0;
      b_stage <= '0;
      a_code  <= '0;
      b_code  <= '0;
      wr_sel  <= 1'b0;
      upd_ph  <= 1'b0;
    end else if (dual_mode) begin
      if (a_wr)  a_stage <= a_data;
      if (a_upd) a_code  <= a_stage;
      if (b_wr)  b_stage <= b_data;
      if (b_upd) b_code  <= b_stage;
    end else begin
      if (a_wr) begin
        if (wr_sel) b_stage <= a_data;
        else        a_stage <= a_data;
        wr_sel <= ~wr_sel;
      end
      if (a_upd) begin
        if (upd_ph) begin
          a_code <= a_stage;
          b_code <= b_stage;
        end
        upd_ph <= ~upd_ph;
      end
    end
  end

  p_hold_a_r4: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && !a_upd) |=> $stable(a_code));
  p_hold_b_r4: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && !b_upd) |=> $stable(b_code));
  p_load_a_r5: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && a_upd) |=> (a_code == $past(a_stage)));
  p_load_b_r5: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && b_upd) |=> (b_code == $past(b_stage)));
  p_stage_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && !a_wr) |=> $stable(a_stage));
  p_il_skip_r8: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && !(a_upd && upd_ph)) |=> ($stable(a_code) && $stable(b_code)));
  p_il_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && a_upd && upd_ph) |=>
      (a_code == $past(a_stage) && b_code == $past(b_stage)));
  p_il_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && !a_wr) |=> ($stable(a_stage) && $stable(b_stage)));
  p_il_one_r7: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && a_wr) |=> ($stable(a_stage) != $stable(b_stage) || $past(a_data) == (wr_sel ? $past(a_stage) : $past(b_stage))));
  p_clear_r10: assert property (@(posedge clk)
    rst |=> (a_code == '0 && b_code == '0 && a_stage == '0 && b_stage == '0));
endmodule

// File: tb/dual_dac_front_tb.sv
module dual_dac_front_tb_top;
  localparam int DW = 14;
  localparam int FS = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dual_mode = 1'b1;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic a_wr = 0, a_upd = 0, b_wr = 0, b_upd = 0;
  logic [DW-1:0] a_code, a_code_n, b_code, b_code_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  int m_stage[2];
  int m_out[2];
  int m_sel, m_ph;
  int q_a[$];
  int q_b[$];

  always #4 clk = ~clk;

  dual_dac_front #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .dual_mode(dual_mode),
    .a_data(a_data), .a_wr(a_wr), .a_upd(a_upd),
    .b_data(b_data), .b_wr(b_wr), .b_upd(b_upd),
    .a_code(a_code), .a_code_n(a_code_n),
    .b_code(b_code), .b_code_n(b_code_n)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_stage = '{0, 0}; m_out = '{0, 0}; m_sel = 0; m_ph = 0;
      q_a.delete(); q_b.delete();
    end else if (dual_mode) begin
      if (a_upd) m_out[0] = m_stage[0];
      if (a_wr) begin m_stage[0] = a_data; q_a.push_back(a_data); end
      if (b_upd) m_out[1] = m_stage[1];
      if (b_wr) begin m_stage[1] = b_data; q_b.push_back(b_data); end
    end else begin
      if (a_upd) begin
        if (m_ph == 1) begin m_out[0] = m_stage[0]; m_out[1] = m_stage[1]; end
        m_ph = 1 - m_ph;
      end
      if (a_wr) begin
        if (m_sel == 1) begin m_stage[1] = a_data; q_b.push_back(a_data); end
        else begin m_stage[0] = a_data; q_a.push_back(a_data); end
        m_sel = 1 - m_sel;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    string t = dual_mode ? "R4/R6" : "R7/R8";
    check({t, " ch0"}, a_code, m_out[0]);
    check({t, " ch1"}, b_code, m_out[1]);
    check("R2 ch0", a_code_n, FS - a_code);
    check("R2 ch1", b_code_n, FS - b_code);
  endtask

  task automatic cyc(input bit aw, input bit au, input int ad,
                     input bit bw, input bit bu, input int bd);
    a_wr = aw; a_upd = au; a_data = ad[DW-1:0];
    b_wr = bw; b_upd = bu; b_data = bd[DW-1:0];
    @(negedge clk);
    compare_model();
  endtask

  task automatic do_reset(input bit mode);
    rst = 1; dual_mode = mode;
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    rst = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset(1);
    check("R10 reset ch0", a_code, 0);
    check("R10 reset ch1", b_code, 0);
    check("R2 reset ch0_n", a_code_n, FS);

    cyc(1, 0, 'h1234, 0, 0, 0);
    check("R3 write alone", a_code, 0);
    cyc(0, 1, 0, 0, 0, 0);
    check("R4 update ch0", a_code, 'h1234);
    check("R6 ch1 untouched", b_code, 0);
    cyc(0, 0, 0, 1, 0, FS);
    cyc(0, 0, 0, 0, 1, 0);
    check("R1 full scale ch1", b_code, FS);
    check("R2 full scale ch1_n", b_code_n, 0);
    check("R6 ch0 kept", a_code, 'h1234);
    cyc(1, 1, 'h0AAA, 0, 0, 0);
    check("R5 same-cycle old word", a_code, 'h1234);
    cyc(0, 1, 0, 0, 0, 0);
    check("R5 new word next update", a_code, 'h0AAA);
    cyc(0, 0, 0, 0, 0, 0);
    check("R1 MSB bit13", q_a[$] >> 13, 0);

    for (int i = 0; i < 300; i++)
      cyc($urandom_range(0, 1), $urandom_range(0, 1), $urandom,
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom);

    do_reset(0);
    cyc(1, 0, 'h0111, 1, 1, 'h3FFF);
    cyc(1, 0, 'h2222, 1, 1, 'h1555);
    cyc(0, 1, 0, 1, 1, 'h0777);
    check("R8 first update holds ch0", a_code, 0);
    check("R9 ch1 strobes ignored", b_code, 0);
    cyc(0, 1, 0, 0, 0, 0);
    check("R7 ch0 got first word", a_code, 'h0111);
    check("R7 ch1 got second word", b_code, 'h2222);
    cyc(1, 0, 'h0333, 1, 0, 'h1FFF);
    cyc(0, 1, 0, 0, 1, 0);
    cyc(0, 1, 0, 0, 0, 0);
    check("R9 ch1 kept", b_code, 'h2222);
    check("R7 ch0 third word", a_code, 'h0333);

    for (int i = 0; i < 400; i++)
      cyc($urandom_range(0, 1), $urandom_range(0, 1), $urandom,
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom);

    rst = 1;
    cyc(0, 0, 0, 0, 0, 0);
    check("R10 mid-run clear ch0", a_code, 0);
    check("R10 mid-run clear ch1", b_code, 0);
    rst = 0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule